// File: doc/BRIEF.md
# Scaler Phase Parameter Calculator

This block derives the setup values a scaling engine needs for the single layer it is allowed to resize. It takes the layer's source width and height in unsigned 16.16 fixed point, the destination width and height as plain integers, a mask of the layers that ask for scaling, and a flag that says whether the layer is turned by a quarter turn. From these it produces, for each axis, an upscale factor in 16.16, a starting phase and a phase step. It also produces a flag that turns on the edge enhancer when the picture is enlarged strongly enough.

All six quotients come from one serial restoring divider that is used six times in turn. A caller raises `start` for one cycle while the block is idle. The block then latches its inputs and runs. It answers with a one-cycle `done`, and the result outputs change in that same cycle. Requests that name no layer, name more than one layer, or carry a zero size finish without running the divider.

Top module: `scl_phase_calc`

## Requirements
- R1: The horizontal upscale factor is (dstW << 32) / srcW and the vertical one is (dstH << 32) / srcH. Each is truncated to its low 32 bits, which gives a 16.16 value. Quarter-turn rotation has no effect on these two factors.
- R2: `enhEn` is 1 when bits 31:16 of either upscale factor are 2 or more, and 0 otherwise.
- R3: With `rotate` = 1, the horizontal input size is srcH[31:16] and the vertical input size is srcW[31:16]. With `rotate` = 0, the horizontal input size is srcW[31:16] and the vertical input size is srcH[31:16].
- R4: The initial phase on each axis is (((input << 4) / output) + 1) / 2, using integer division. The output is dstW for the horizontal axis and dstH for the vertical axis.
- R5: The phase step on each axis is (input << 16) / output, using integer division.
- R6: A mask with more than one bit set ends with `err` = 1 and `scaleEn` = 0. All numeric outputs and `enhEn` keep their previous values.
- R7: A one-hot mask with a zero srcW, srcH, dstW or dstH ends with `err` = 1 and `scaleEn` = 0. All numeric outputs and `enhEn` keep their previous values.
- R8: An all-zero mask ends with `err` = 0 and `scaleEn` = 0. All numeric outputs and `enhEn` keep their previous values, whatever the sizes are.
- R9: A successful request ends with `err` = 0 and `scaleEn` = 1, and all outputs are updated.
- R10: `done` is high for exactly one cycle per accepted request, and the results change only in that cycle. A `start` raised while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `err`, `scaleEn` and `enhEn` are 0 and every numeric output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when idle |
| layerMask | input | LAYERS | One bit per layer asking for scaling |
| rotate | input | 1 | Layer is turned by 90 or 270 degrees |
| srcW | input | INT_W+FRAC_W | Source width, unsigned 16.16 |
| srcH | input | INT_W+FRAC_W | Source height, unsigned 16.16 |
| dstW | input | INT_W | Destination width, integer |
| dstH | input | INT_W | Destination height, integer |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was rejected |
| scaleEn | output | 1 | Last request produced valid scaling values |
| enhEn | output | 1 | Edge enhancer enable |
| hUpscale | output | INT_W+FRAC_W | Horizontal upscale factor, 16.16 |
| vUpscale | output | INT_W+FRAC_W | Vertical upscale factor, 16.16 |
| hInitPhase | output | INT_W+FRAC_W | Horizontal initial phase |
| vInitPhase | output | INT_W+FRAC_W | Vertical initial phase |
| hDeltaPhase | output | INT_W+FRAC_W | Horizontal phase step |
| vDeltaPhase | output | INT_W+FRAC_W | Vertical phase step |

## Verification
The bench uses the default parameters: four layers, 16.16 sizes, four phase bits and a twelve-bit sub-shift. With these values the divider runs its full 64 iterations on a 64-bit dividend. Source sizes with non-zero fractions and small integer parts reach upscale quotients that need the 32-bit truncation. The 16-bit integer field is wide enough for the 2.0 enhancer threshold to be hit exactly, and the rounding of the initial phase shows up with odd quotients.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int NUM_DIVS = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_DIV} sclState_t;

  typedef struct packed {
    logic       latchIn;
    logic       divStart;
    logic       store;
    logic       commit;
    logic       reject;
    logic       skip;
    logic [2:0] opSel;
    logic [2:0] storeSel;
  } sclStrobe_t;
endpackage

// File: rtl/scl_divider.sv
module scl_divider #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] remQ;
  logic [DEN_W-1:0] denQ;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   trial;
  logic             ge;

  always_comb begin
    trial = {remQ, quo[NUM_W-1]};
    ge    = (trial >= {1'b0, denQ});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remQ <= '0;
      denQ <= '0;
      quo  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        remQ <= '0;
        denQ <= den;
        quo  <= num;
        cnt  <= CNT_W'(NUM_W);
      end else if (cnt != '0) begin
        remQ <= ge ? DEN_W'(trial - {1'b0, denQ}) : DEN_W'(trial);
        quo  <= {quo[NUM_W-2:0], ge};
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import scl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       noneReq,
  input  logic       badReq,
  input  logic       divDone,
  output sclStrobe_t strb,
  output logic       busy,
  output logic       done
);
  sclState_t state, stateNext;
  logic [2:0] step, stepNext;
  logic finish;

  always_comb begin
    strb      = '0;
    stateNext = state;
    stepNext  = step;
    finish    = 1'b0;
    strb.storeSel = step;
    strb.opSel    = step;
    case (state)
      ST_IDLE: if (start) begin
        strb.latchIn = 1'b1;
        stateNext    = ST_EVAL;
      end
      ST_EVAL: begin
        if (noneReq) begin
          strb.skip = 1'b1;
          finish    = 1'b1;
          stateNext = ST_IDLE;
        end else if (badReq) begin
          strb.reject = 1'b1;
          finish      = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          strb.divStart = 1'b1;
          strb.opSel    = 3'd0;
          stepNext      = 3'd0;
          stateNext     = ST_DIV;
        end
      end
      ST_DIV: if (divDone) begin
        strb.store = 1'b1;
        if (step == 3'(NUM_DIVS - 1)) begin
          strb.commit = 1'b1;
          finish      = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          stepNext      = step + 1'b1;
          strb.opSel    = step + 1'b1;
          strb.divStart = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      step  <= stepNext;
      done  <= finish;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/scl_datapath.sv
module scl_datapath
  import scl_pkg::*;
#(
  parameter int LAYERS     = 4,
  parameter int INT_W      = 16,
  parameter int FRAC_W     = 16,
  parameter int PHASE_BITS = 4,
  parameter int SUB_SHIFT  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  sclStrobe_t              strb,
  input  logic [LAYERS-1:0]       layerMask,
  input  logic                    rotate,
  input  logic [INT_W+FRAC_W-1:0] srcW,
  input  logic [INT_W+FRAC_W-1:0] srcH,
  input  logic [INT_W-1:0]        dstW,
  input  logic [INT_W-1:0]        dstH,
  input  logic [2*(INT_W+FRAC_W)-1:0] divQuo,
  output logic [2*(INT_W+FRAC_W)-1:0] divNum,
  output logic [INT_W+FRAC_W-1:0] divDen,
  output logic                    noneReq,
  output logic                    badReq,
  output logic                    err,
  output logic                    scaleEn,
  output logic                    enhEn,
  output logic [INT_W+FRAC_W-1:0] res [NUM_DIVS]
);
  localparam int SRC_W = INT_W + FRAC_W;
  localparam int NUM_W = 2 * SRC_W;
  localparam int UP_SH = 2 * FRAC_W;
  localparam int DL_SH = PHASE_BITS + SUB_SHIFT;

  logic [LAYERS-1:0] maskQ;
  logic              rotQ;
  logic [SRC_W-1:0]  srcWq, srcHq;
  logic [INT_W-1:0]  dstWq, dstHq, inW, inH;
  logic [SRC_W-1:0]  stage [NUM_DIVS];
  logic [SRC_W-1:0]  stageNext [NUM_DIVS];
  logic [SRC_W:0]    rounded;

  always_comb begin
    noneReq = (maskQ == '0);
    badReq  = ((maskQ & (maskQ - 1'b1)) != '0) || (srcWq == '0) ||
              (srcHq == '0) || (dstWq == '0) || (dstHq == '0);
    inW = rotQ ? srcHq[SRC_W-1:FRAC_W] : srcWq[SRC_W-1:FRAC_W];
    inH = rotQ ? srcWq[SRC_W-1:FRAC_W] : srcHq[SRC_W-1:FRAC_W];
  end

  always_comb begin
    divNum = '0;
    divDen = '0;
    case (strb.opSel)
      3'd0: begin divNum = NUM_W'(dstWq) << UP_SH;     divDen = srcWq; end
      3'd1: begin divNum = NUM_W'(dstHq) << UP_SH;     divDen = srcHq; end
      3'd2: begin divNum = NUM_W'(inW) << PHASE_BITS;  divDen = SRC_W'(dstWq); end
      3'd3: begin divNum = NUM_W'(inW) << DL_SH;       divDen = SRC_W'(dstWq); end
      3'd4: begin divNum = NUM_W'(inH) << PHASE_BITS;  divDen = SRC_W'(dstHq); end
      default: begin divNum = NUM_W'(inH) << DL_SH;    divDen = SRC_W'(dstHq); end
    endcase
  end

  always_comb begin
    rounded = ({1'b0, divQuo[SRC_W-1:0]} + 1'b1) >> 1;
    for (int i = 0; i < NUM_DIVS; i++) begin
      stageNext[i] = stage[i];
      if (strb.store && (strb.storeSel == 3'(i)))
        stageNext[i] = (i == 2 || i == 4) ? rounded[SRC_W-1:0] : divQuo[SRC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskQ <= '0; rotQ <= 1'b0;
      srcWq <= '0; srcHq <= '0; dstWq <= '0; dstHq <= '0;
      err <= 1'b0; scaleEn <= 1'b0; enhEn <= 1'b0;
      for (int i = 0; i < NUM_DIVS; i++) begin
        stage[i] <= '0;
        res[i]   <= '0;
      end
    end else begin
      if (strb.latchIn) begin
        maskQ <= layerMask; rotQ <= rotate;
        srcWq <= srcW; srcHq <= srcH; dstWq <= dstW; dstHq <= dstH;
      end
      for (int i = 0; i < NUM_DIVS; i++) stage[i] <= stageNext[i];
      if (strb.skip)   begin err <= 1'b0; scaleEn <= 1'b0; end
      if (strb.reject) begin err <= 1'b1; scaleEn <= 1'b0; end
      if (strb.commit) begin
        err     <= 1'b0;
        scaleEn <= 1'b1;
        enhEn   <= (stageNext[0][SRC_W-1:FRAC_W] >= INT_W'(2)) ||
                   (stageNext[1][SRC_W-1:FRAC_W] >= INT_W'(2));
        for (int i = 0; i < NUM_DIVS; i++) res[i] <= stageNext[i];
      end
    end
  end
endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import scl_pkg::*;
#(
  parameter int LAYERS     = 4,
  parameter int INT_W      = 16,
  parameter int FRAC_W     = 16,
  parameter int PHASE_BITS = 4,
  parameter int SUB_SHIFT  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [LAYERS-1:0]       layerMask,
  input  logic                    rotate,
  input  logic [INT_W+FRAC_W-1:0] srcW,
  input  logic [INT_W+FRAC_W-1:0] srcH,
  input  logic [INT_W-1:0]        dstW,
  input  logic [INT_W-1:0]        dstH,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  output logic                    scaleEn,
  output logic                    enhEn,
  output logic [INT_W+FRAC_W-1:0] hUpscale,
  output logic [INT_W+FRAC_W-1:0] vUpscale,
  output logic [INT_W+FRAC_W-1:0] hInitPhase,
  output logic [INT_W+FRAC_W-1:0] vInitPhase,
  output logic [INT_W+FRAC_W-1:0] hDeltaPhase,
  output logic [INT_W+FRAC_W-1:0] vDeltaPhase
);
  localparam int SRC_W = INT_W + FRAC_W;
  localparam int NUM_W = 2 * SRC_W;

  sclStrobe_t       strb;
  logic             noneReq, badReq, divDone;
  logic [NUM_W-1:0] divNum, divQuo;
  logic [SRC_W-1:0] divDen;
  logic [SRC_W-1:0] res [NUM_DIVS];

  scl_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .noneReq(noneReq), .badReq(badReq),
    .divDone(divDone), .strb(strb), .busy(busy), .done(done)
  );

  scl_datapath #(
    .LAYERS(LAYERS), .INT_W(INT_W), .FRAC_W(FRAC_W),
    .PHASE_BITS(PHASE_BITS), .SUB_SHIFT(SUB_SHIFT)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .layerMask(layerMask), .rotate(rotate),
    .srcW(srcW), .srcH(srcH), .dstW(dstW), .dstH(dstH), .divQuo(divQuo),
    .divNum(divNum), .divDen(divDen), .noneReq(noneReq), .badReq(badReq),
    .err(err), .scaleEn(scaleEn), .enhEn(enhEn), .res(res)
  );

  scl_divider #(.NUM_W(NUM_W), .DEN_W(SRC_W)) u_div (
    .clk(clk), .rst(rst), .start(strb.divStart), .num(divNum), .den(divDen),
    .quo(divQuo), .done(divDone)
  );

  assign hUpscale    = res[0];
  assign vUpscale    = res[1];
  assign hInitPhase  = res[2];
  assign hDeltaPhase = res[3];
  assign vInitPhase  = res[4];
  assign vDeltaPhase = res[5];
endmodule

// File: rtl/scl_phase_calc_chk.sv
module scl_phase_calc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         err,
  input logic         scaleEn,
  input logic         enhEn,
  input logic [W-1:0] hUpscale,
  input logic [W-1:0] hInitPhase,
  input logic [W-1:0] vDeltaPhase
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R6
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !scaleEn);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(hUpscale) && $stable(hInitPhase) &&
               $stable(vDeltaPhase) && $stable(enhEn)));

  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind scl_phase_calc scl_phase_calc_chk #(.W(INT_W + FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .err(err),
  .scaleEn(scaleEn), .enhEn(enhEn), .hUpscale(hUpscale),
  .hInitPhase(hInitPhase), .vDeltaPhase(vDeltaPhase)
);

// File: tb/sim_scl_phase_calc.sv
module sim_scl_phase_calc;
  localparam int LAYERS = 4;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 16;
  localparam int W      = INT_W + FRAC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LAYERS-1:0] layerMask = '0;
  logic rotate = 1'b0;
  logic [W-1:0] srcW = '0, srcH = '0;
  logic [INT_W-1:0] dstW = '0, dstH = '0;
  logic busy, done, err, scaleEn, enhEn;
  logic [W-1:0] hUpscale, vUpscale, hInitPhase, vInitPhase, hDeltaPhase, vDeltaPhase;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [W-1:0] eHU = '0, eVU = '0, eHI = '0, eVI = '0, eHD = '0, eVD = '0;
  logic eEnh = 1'b0;

  always #2 clk = ~clk;

  scl_phase_calc u0 (
    .clk(clk), .rst(rst), .start(start), .layerMask(layerMask), .rotate(rotate),
    .srcW(srcW), .srcH(srcH), .dstW(dstW), .dstH(dstH), .busy(busy), .done(done),
    .err(err), .scaleEn(scaleEn), .enhEn(enhEn), .hUpscale(hUpscale),
    .vUpscale(vUpscale), .hInitPhase(hInitPhase), .vInitPhase(vInitPhase),
    .hDeltaPhase(hDeltaPhase), .vDeltaPhase(vDeltaPhase)
  );

  function automatic logic [W-1:0] fUp(logic [INT_W-1:0] d, logic [W-1:0] s);
    longint unsigned n = longint'(d) << 32;
    return W'(n / longint'(s));
  endfunction

  function automatic logic [W-1:0] fInit(logic [INT_W-1:0] i, logic [INT_W-1:0] o);
    longint unsigned q = (longint'(i) << 4) / longint'(o);
    return W'((q + 1) / 2);
  endfunction

  function automatic logic [W-1:0] fDelta(logic [INT_W-1:0] i, logic [INT_W-1:0] o);
    return W'((longint'(i) << 16) / longint'(o));
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runOp(logic [LAYERS-1:0] m, logic r, logic [W-1:0] sw, logic [W-1:0] sh,
                       logic [INT_W-1:0] dw, logic [INT_W-1:0] dh, logic poke);
    logic [INT_W-1:0] iw, ih;
    int n = 0;
    @(negedge clk);
    layerMask = m; rotate = r; srcW = sw; srcH = sh; dstW = dw; dstH = dh; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      layerMask = 4'b0001; srcW = 32'h0001_0000; dstW = 16'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (m == '0) begin
      // R8: nothing requested, results held
      check("R8 err", W'(err), 0);
      check("R8 scaleEn", W'(scaleEn), 0);
    end else if (((m & (m - 1'b1)) != '0) || sw == 0 || sh == 0 || dw == 0 || dh == 0) begin
      // R6 / R7: rejected, results held
      check((m & (m - 1'b1)) != '0 ? "R6 err" : "R7 err", W'(err), 1);
      check("R6/R7 scaleEn", W'(scaleEn), 0);
    end else begin
      iw = r ? sh[W-1:FRAC_W] : sw[W-1:FRAC_W];
      ih = r ? sw[W-1:FRAC_W] : sh[W-1:FRAC_W];
      eHU = fUp(dw, sw); eVU = fUp(dh, sh);
      eHI = fInit(iw, dw); eVI = fInit(ih, dh);
      eHD = fDelta(iw, dw); eVD = fDelta(ih, dh);
      eEnh = (eHU[W-1:FRAC_W] >= 2) || (eVU[W-1:FRAC_W] >= 2);
      check("R9 err", W'(err), 0);
      check("R9 scaleEn", W'(scaleEn), 1);
    end
    check("R10 done seen", W'(done), 1);
    check("R1 hUpscale", hUpscale, eHU);
    check("R1 vUpscale", vUpscale, eVU);
    check("R2 enhEn", W'(enhEn), W'(eEnh));
    check("R3/R4 hInitPhase", hInitPhase, eHI);
    check("R3/R4 vInitPhase", vInitPhase, eVI);
    check("R3/R5 hDeltaPhase", hDeltaPhase, eHD);
    check("R3/R5 vDeltaPhase", vDeltaPhase, eVD);
    @(negedge clk);
    check("R10 done one cycle", W'(done), 0);
    check("R10 idle after", W'(busy), 0);
  endtask

  initial begin
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected<190000", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 busy", W'(busy), 0);
    check("R11 done", W'(done), 0);
    check("R11 err", W'(err), 0);
    check("R11 scaleEn", W'(scaleEn), 0);
    check("R11 hUpscale", hUpscale, 0);
    check("R11 vDeltaPhase", vDeltaPhase, 0);
    rst = 1'b0;
    // R2 exact 2.0 on horizontal
    runOp(4'b0010, 1'b0, 32'h0064_0000, 32'h0064_0000, 16'd200, 16'd100, 1'b0);
    // R2 just below 2.0 on both axes
    runOp(4'b0001, 1'b0, 32'h0064_0000, 32'h0064_0000, 16'd199, 16'd199, 1'b0);
    // R2 vertical only
    runOp(4'b0100, 1'b0, 32'h0064_0000, 32'h0032_0000, 16'd120, 16'd150, 1'b0);
    // R3 rotation
    runOp(4'b1000, 1'b1, 32'h0280_0000, 32'h01E0_0000, 16'd1280, 16'd960, 1'b0);
    // R8 no layer, sizes even zero
    runOp(4'b0000, 1'b0, 32'h0000_0000, 32'h0010_0000, 16'd5, 16'd9, 1'b0);
    // R6 two layers
    runOp(4'b0101, 1'b0, 32'h0100_0000, 32'h0100_0000, 16'd300, 16'd300, 1'b0);
    // R7 zero output and zero source
    runOp(4'b0001, 1'b0, 32'h0100_0000, 32'h0100_0000, 16'd0, 16'd300, 1'b0);
    runOp(4'b0010, 1'b1, 32'h0100_0000, 32'h0000_0000, 16'd40, 16'd300, 1'b0);
    // R1 tiny source, truncated factor
    runOp(4'b0001, 1'b0, 32'h0000_8001, 32'h0003_0007, 16'd65535, 16'd3, 1'b0);
    // R10 start while busy is ignored
    runOp(4'b0010, 1'b0, 32'h0320_8000, 32'h0258_4000, 16'd1920, 16'd1080, 1'b1);
    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] sw, sh;
      sw = {16'(1 + $urandom % 1500), 16'($urandom)};
      sh = {16'(1 + $urandom % 1500), 16'($urandom)};
      runOp(4'(1 << ($urandom % 4)), 1'($urandom), sw, sh,
            16'(1 + $urandom % 3000), 16'(1 + $urandom % 3000), 1'($urandom % 5 == 0));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule